// File: doc/BRIEF.md
# Trap entry unit

This unit decides where a trap goes and produces the architectural state changes that taking it implies. The pipeline presents a one-cycle trap strobe along with the cause, the PC of the faulting instruction and an optional bad address. It also supplies the current privilege, the current status-stack bits, the two delegation masks, the two trap-vector bases, the per-privilege breakpoint enables and a flag saying the hart is already halted in debug mode.

One cycle later the unit emits a single update pulse. The pulse carries the next PC, the next privilege and the next status bits. It also carries write enables for the supervisor and machine trap-record registers, their bad-address registers and the debug save registers, plus a request to drop the load reservation.

The trap, its cause, its epc, its address and the privilege it was taken from are registered on every strobe. The register file that owns them writes those values wherever the enables point.

The unit distinguishes four routes:
- A trap taken while already in debug mode only redirects the PC into the debug ROM.
- A breakpoint whose per-privilege enable is set enters debug mode.
- A trap whose delegation bit matches, taken from S or U, goes to the supervisor handler.
- Every other trap goes to the machine handler. That handler supports a vectored layout for interrupts.

Top module: `trap_unit`

## Requirements
- R1: After reset, upd_o, every write enable and resv_clr_o are low.
- R2: upd_o is high in exactly the cycle after each cycle in which trap_valid_i is high, and low otherwise. Back-to-back strobes give back-to-back updates, and epc_o, cause_o, addr_o and prev_priv_o carry that trap's inputs.
- R3: With in_debug_i high, a breakpoint gives next_pc_o = DBG_ENTRY and any other trap gives DBG_TVEC. The privilege and status are unchanged, no write enable rises and resv_clr_o stays low.
- R4: A breakpoint is a trap_cause_i with MSB 0 and code 3. Outside debug mode, a breakpoint enters debug when ebreak_en_i[p] is set, where bit 0 is U, bit 1 is S and bit 2 is M, chosen by the current privilege (U=0, S=1, M=3). Entry raises dbg_we_o, sets next_pc_o = DBG_ENTRY and next privilege M, and leaves the status unchanged. prev_priv_o carries the old privilege.
- R5: trap_cause_i MSB set marks an interrupt. The delegation lookup uses mideleg_i for interrupts and medeleg_i for exceptions, indexed by the cause with its MSB cleared.
- R6: A trap goes to the supervisor handler only if the current privilege is U or S, the index is below XLEN and the selected delegation bit is set. Otherwise it goes to the machine handler.
- R7: Supervisor entry sets next_pc_o = stvec_i and next privilege S, and raises s_we_o. Status is encoded {mpp[6:5], spp[4], mpie[3], spie[2], mie[1], sie[0]}. On entry spie takes the old sie, spp takes bit 0 of the old privilege and sie clears. The machine bits are unchanged.
- R8: Machine entry sets next_pc_o = mtvec_i with bit 0 cleared. When mtvec_i[0] is set and the trap is an interrupt, 4 times the index is added.
- R9: Machine entry raises m_we_o and sets next privilege M. mpie takes the old mie, mpp takes the old privilege and mie clears. The supervisor bits are unchanged.
- R10: s_addr_we_o or m_addr_we_o rises together with its entry enable only when trap_addr_vld_i was set with the trap.
- R11: resv_clr_o rises on supervisor and machine entries, never on debug routes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | Trap strobe |
| trap_cause_i | input | XLEN | Cause, MSB = interrupt |
| trap_epc_i | input | XLEN | PC of the trapping instruction |
| trap_addr_i | input | XLEN | Faulting address |
| trap_addr_vld_i | input | 1 | Cause carries an address |
| cur_priv_i | input | 2 | Current privilege |
| in_debug_i | input | 1 | Hart is in debug mode |
| status_i | input | 7 | Current status-stack bits |
| ebreak_en_i | input | 3 | Breakpoint-to-debug enables {M,S,U} |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor vector base |
| mtvec_i | input | XLEN | Machine vector base, bit 0 = vectored |
| upd_o | output | 1 | Update pulse |
| next_pc_o | output | XLEN | Next PC |
| next_priv_o | output | 2 | Next privilege |
| status_o | output | 7 | Next status-stack bits |
| s_we_o | output | 1 | Write supervisor epc and cause |
| s_addr_we_o | output | 1 | Write supervisor bad address |
| m_we_o | output | 1 | Write machine epc and cause |
| m_addr_we_o | output | 1 | Write machine bad address |
| dbg_we_o | output | 1 | Write debug PC, privilege and cause |
| epc_o | output | XLEN | Registered epc |
| cause_o | output | XLEN | Registered cause |
| addr_o | output | XLEN | Registered bad address |
| prev_priv_o | output | 2 | Privilege the trap was taken from |
| resv_clr_o | output | 1 | Drop load reservation |

## Verification
The assertions check the properties that hold on every cycle:
- the strobe-to-pulse timing;
- that at most one route enable is raised;
- the privilege and cleared interrupt-enable bit on each entry;
- debug-mode traps never touching registers or the reservation;
- machine privilege never delegating;
- address enables only following a flagged address.

The specific values need the scoreboard scenarios. These include the vector PC arithmetic, the choice between mideleg and medeleg, the out-of-range index falling to machine mode, the status-stack shuffles and which breakpoint enable applies at each privilege.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;
  localparam int unsigned BRK_CODE = 3;

  typedef struct packed {
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } stat_t;

  typedef enum logic [1:0] {
    RT_DBG_ROM,
    RT_DBG_ENTER,
    RT_SUPER,
    RT_MACHINE
  } route_e;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [1:0]      priv_i,
  input  logic            in_debug_i,
  input  logic [2:0]      ebreak_en_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  output route_e          route_o,
  output logic            is_intr_o,
  output logic            is_brk_o,
  output logic [XLEN-2:0] idx_o
);
  localparam int unsigned IDXW = $clog2(XLEN);

  logic [XLEN-1:0] mask;
  logic            brk_en;
  logic            deleg;

  assign is_intr_o = cause_i[XLEN-1];
  assign idx_o     = cause_i[XLEN-2:0];
  assign is_brk_o  = !is_intr_o && (idx_o == (XLEN-1)'(BRK_CODE));
  assign mask      = is_intr_o ? mideleg_i : medeleg_i;

  always_comb begin
    case (priv_i)
      PRV_U:   brk_en = ebreak_en_i[0];
      PRV_S:   brk_en = ebreak_en_i[1];
      PRV_M:   brk_en = ebreak_en_i[2];
      default: brk_en = 1'b0;
    endcase
  end

  assign deleg = (priv_i <= PRV_S) && (idx_o < (XLEN-1)'(XLEN)) && mask[idx_o[IDXW-1:0]];

  always_comb begin
    if (in_debug_i)               route_o = RT_DBG_ROM;
    else if (is_brk_o && brk_en)  route_o = RT_DBG_ENTER;
    else if (deleg)               route_o = RT_SUPER;
    else                          route_o = RT_MACHINE;
  end
endmodule

// File: rtl/trap_vec.sv
module trap_vec
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
  parameter logic [XLEN-1:0] DBG_TVEC  = 'h808
) (
  input  route_e          route_i,
  input  logic            is_intr_i,
  input  logic            is_brk_i,
  input  logic [XLEN-2:0] idx_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] mtvec_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] m_base;
  logic [XLEN-1:0] m_off;

  assign m_base = {mtvec_i[XLEN-1:1], 1'b0};
  assign m_off  = (mtvec_i[0] && is_intr_i) ? {idx_i[XLEN-3:0], 2'b00} : '0;

  always_comb begin
    case (route_i)
      RT_DBG_ROM:   pc_o = is_brk_i ? DBG_ENTRY : DBG_TVEC;
      RT_DBG_ENTER: pc_o = DBG_ENTRY;
      RT_SUPER:     pc_o = stvec_i;
      default:      pc_o = m_base + m_off;
    endcase
  end
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
(
  input  route_e     route_i,
  input  logic [1:0] priv_i,
  input  stat_t      stat_i,
  input  logic       addr_vld_i,
  output logic [1:0] priv_o,
  output stat_t      stat_o,
  output logic       s_we_o,
  output logic       s_addr_we_o,
  output logic       m_we_o,
  output logic       m_addr_we_o,
  output logic       dbg_we_o,
  output logic       resv_clr_o
);
  always_comb begin
    priv_o      = priv_i;
    stat_o      = stat_i;
    s_we_o      = 1'b0;
    s_addr_we_o = 1'b0;
    m_we_o      = 1'b0;
    m_addr_we_o = 1'b0;
    dbg_we_o    = 1'b0;
    resv_clr_o  = 1'b0;
    case (route_i)
      RT_DBG_ENTER: begin
        priv_o   = PRV_M;
        dbg_we_o = 1'b1;
      end
      RT_SUPER: begin
        priv_o      = PRV_S;
        stat_o.spie = stat_i.sie;
        stat_o.spp  = priv_i[0];
        stat_o.sie  = 1'b0;
        s_we_o      = 1'b1;
        s_addr_we_o = addr_vld_i;
        resv_clr_o  = 1'b1;
      end
      RT_MACHINE: begin
        priv_o      = PRV_M;
        stat_o.mpie = stat_i.mie;
        stat_o.mpp  = priv_i;
        stat_o.mie  = 1'b0;
        m_we_o      = 1'b1;
        m_addr_we_o = addr_vld_i;
        resv_clr_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
  parameter logic [XLEN-1:0] DBG_TVEC  = 'h808
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_valid_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_epc_i,
  input  logic [XLEN-1:0] trap_addr_i,
  input  logic            trap_addr_vld_i,
  input  logic [1:0]      cur_priv_i,
  input  logic            in_debug_i,
  input  logic [6:0]      status_i,
  input  logic [2:0]      ebreak_en_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] mtvec_i,
  output logic            upd_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [1:0]      next_priv_o,
  output logic [6:0]      status_o,
  output logic            s_we_o,
  output logic            s_addr_we_o,
  output logic            m_we_o,
  output logic            m_addr_we_o,
  output logic            dbg_we_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] addr_o,
  output logic [1:0]      prev_priv_o,
  output logic            resv_clr_o
);
  route_e          route;
  logic            is_intr, is_brk;
  logic [XLEN-2:0] idx;
  logic [XLEN-1:0] pc_d;
  logic [1:0]      priv_d;
  stat_t           stat_d;
  logic            s_we_d, s_awe_d, m_we_d, m_awe_d, d_we_d, resv_d;

  trap_route #(.XLEN(XLEN)) u_route (
    .cause_i     (trap_cause_i),
    .priv_i      (cur_priv_i),
    .in_debug_i  (in_debug_i),
    .ebreak_en_i (ebreak_en_i),
    .medeleg_i   (medeleg_i),
    .mideleg_i   (mideleg_i),
    .route_o     (route),
    .is_intr_o   (is_intr),
    .is_brk_o    (is_brk),
    .idx_o       (idx)
  );

  trap_vec #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY), .DBG_TVEC(DBG_TVEC)) u_vec (
    .route_i   (route),
    .is_intr_i (is_intr),
    .is_brk_i  (is_brk),
    .idx_i     (idx),
    .stvec_i   (stvec_i),
    .mtvec_i   (mtvec_i),
    .pc_o      (pc_d)
  );

  trap_state u_state (
    .route_i     (route),
    .priv_i      (cur_priv_i),
    .stat_i      (stat_t'(status_i)),
    .addr_vld_i  (trap_addr_vld_i),
    .priv_o      (priv_d),
    .stat_o      (stat_d),
    .s_we_o      (s_we_d),
    .s_addr_we_o (s_awe_d),
    .m_we_o      (m_we_d),
    .m_addr_we_o (m_awe_d),
    .dbg_we_o    (d_we_d),
    .resv_clr_o  (resv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_o       <= 1'b0;
      s_we_o      <= 1'b0;
      s_addr_we_o <= 1'b0;
      m_we_o      <= 1'b0;
      m_addr_we_o <= 1'b0;
      dbg_we_o    <= 1'b0;
      resv_clr_o  <= 1'b0;
      next_pc_o   <= '0;
      next_priv_o <= PRV_M;
      status_o    <= '0;
      epc_o       <= '0;
      cause_o     <= '0;
      addr_o      <= '0;
      prev_priv_o <= PRV_M;
    end else begin
      upd_o       <= trap_valid_i;
      s_we_o      <= trap_valid_i && s_we_d;
      s_addr_we_o <= trap_valid_i && s_awe_d;
      m_we_o      <= trap_valid_i && m_we_d;
      m_addr_we_o <= trap_valid_i && m_awe_d;
      dbg_we_o    <= trap_valid_i && d_we_d;
      resv_clr_o  <= trap_valid_i && resv_d;
      if (trap_valid_i) begin
        next_pc_o   <= pc_d;
        next_priv_o <= priv_d;
        status_o    <= stat_d;
        epc_o       <= trap_epc_i;
        cause_o     <= trap_cause_i;
        addr_o      <= trap_addr_i;
        prev_priv_o <= cur_priv_i;
      end
    end
  end
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 'h800
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_valid_i,
  input logic            trap_addr_vld_i,
  input logic [1:0]      cur_priv_i,
  input logic            in_debug_i,
  input logic            upd_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic [1:0]      next_priv_o,
  input logic [6:0]      status_o,
  input logic            s_we_o,
  input logic            s_addr_we_o,
  input logic            m_we_o,
  input logic            m_addr_we_o,
  input logic            dbg_we_o,
  input logic            resv_clr_o
);
  // R2
  upd_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> upd_o);
  // R2
  no_spurious_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> !upd_o);
  // R3
  dbg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && in_debug_i) |=> !(s_we_o || m_we_o || dbg_we_o || resv_clr_o));
  // R6
  route_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({s_we_o, m_we_o, dbg_we_o}));
  // R6
  m_no_deleg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && cur_priv_i == 2'd3) |=> !s_we_o);
  // R7
  s_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_we_o |-> (next_priv_o == 2'd1 && !status_o[0]));
  // R9
  m_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_we_o |-> (next_priv_o == 2'd3 && !status_o[1]));
  // R4
  dbg_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_we_o |-> (next_pc_o == DBG_ENTRY && next_priv_o == 2'd3));
  // R10
  addr_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_addr_we_o || m_addr_we_o) |-> $past(trap_addr_vld_i));
  // R11
  resv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_clr_o |-> (s_we_o || m_we_o));
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY)) u_chk (.*);

// File: tb/tb_trap_unit.sv
`timescale 1ns/1ps
module tb_trap_unit;
  localparam int XLEN = 32;
  localparam logic [31:0] ENTRY = 32'h800;
  localparam logic [31:0] TVEC  = 32'h808;

  typedef struct packed {
    logic [31:0] pc;
    logic [1:0]  priv;
    logic [6:0]  st;
    logic        s_we, s_awe, m_we, m_awe, d_we, resv;
    logic [31:0] epc, cause, addr;
    logic [1:0]  pprv;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic [31:0] cause = '0, epc = '0, addr = '0;
  logic        avld = 1'b0;
  logic [1:0]  priv = 2'd3;
  logic        in_dbg = 1'b0;
  logic [6:0]  st = '0;
  logic [2:0]  ebk = '0;
  logic [31:0] medeleg = '0, mideleg = '0, stvec = '0, mtvec = '0;

  logic        upd, s_we, s_awe, m_we, m_awe, d_we, resv;
  logic [31:0] npc, epc_q, cause_q, addr_q;
  logic [1:0]  npriv, pprv;
  logic [6:0]  nst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t  q[$];
  string tq[$];

  always #2.5 clk = ~clk;

  trap_unit #(.XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(trap_valid), .trap_cause_i(cause),
    .trap_epc_i(epc), .trap_addr_i(addr), .trap_addr_vld_i(avld), .cur_priv_i(priv),
    .in_debug_i(in_dbg), .status_i(st), .ebreak_en_i(ebk), .medeleg_i(medeleg),
    .mideleg_i(mideleg), .stvec_i(stvec), .mtvec_i(mtvec), .upd_o(upd),
    .next_pc_o(npc), .next_priv_o(npriv), .status_o(nst), .s_we_o(s_we),
    .s_addr_we_o(s_awe), .m_we_o(m_we), .m_addr_we_o(m_awe), .dbg_we_o(d_we),
    .epc_o(epc_q), .cause_o(cause_q), .addr_o(addr_q), .prev_priv_o(pprv),
    .resv_clr_o(resv)
  );

  function automatic exp_t model();
    exp_t e;
    logic intr, brk, en, dlg;
    logic [31:0] code, msk;
    e = '0;
    intr = cause[31];
    code = {1'b0, cause[30:0]};
    brk  = !intr && code == 32'd3;
    en   = (priv == 2'd0) ? ebk[0] : (priv == 2'd1) ? ebk[1] : (priv == 2'd3) ? ebk[2] : 1'b0;
    msk  = intr ? mideleg : medeleg;
    dlg  = (priv == 2'd0 || priv == 2'd1) && code < 32 && msk[code[4:0]];
    e.epc = epc; e.cause = cause; e.addr = addr; e.pprv = priv;
    e.st = st; e.priv = priv;
    if (in_dbg) begin
      e.pc = brk ? ENTRY : TVEC;
    end else if (brk && en) begin
      e.pc = ENTRY; e.priv = 2'd3; e.d_we = 1'b1;
    end else if (dlg) begin
      e.pc = stvec; e.priv = 2'd1;
      e.st[2] = st[0]; e.st[4] = priv[0]; e.st[0] = 1'b0;
      e.s_we = 1'b1; e.s_awe = avld; e.resv = 1'b1;
    end else begin
      e.pc = {mtvec[31:1], 1'b0} + ((mtvec[0] && intr) ? (code << 2) : 32'd0);
      e.priv = 2'd3;
      e.st[3] = st[1]; e.st[6:5] = priv; e.st[1] = 1'b0;
      e.m_we = 1'b1; e.m_awe = avld; e.resv = 1'b1;
    end
    return e;
  endfunction

  // driver: sets inputs at negedge, strobes for one cycle, pushes expectation
  task automatic issue(input string tag, input logic [31:0] c, input logic [1:0] p,
                       input logic [6:0] s, input logic av, input logic dbg);
    cause = c; priv = p; st = s; avld = av; in_dbg = dbg;
    epc = 32'h4000_0000 | {c[7:0], 4'h4}; addr = 32'hBAD0_0000 | c[15:0];
    trap_valid = 1'b1;
    q.push_back(model());
    tq.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    trap_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each update pulse with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && upd) begin
      exp_t a, e;
      string t;
      a = '{npc, npriv, nst, s_we, s_awe, m_we, m_awe, d_we, resv, epc_q, cause_q, addr_q, pprv};
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected update: actual=%h expected=none", a);
      end else begin
        e = q.pop_front();
        t = tq.pop_front();
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({upd, s_we, s_awe, m_we, m_awe, d_we, resv} !== 7'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%b expected=0000000",
               {upd, s_we, s_awe, m_we, m_awe, d_we, resv});
    end
    rst_n = 1'b1;
    idle(2);

    mtvec = 32'h0000_1001; stvec = 32'h0000_2000;
    medeleg = 32'hFFFF_FFFF; mideleg = 32'h0;
    // R6 machine privilege never delegates; R8 exception ignores vector mode
    issue("R6_R8 M-priv exception", 32'd8, 2'd3, 7'b0000011, 1'b1, 1'b0);
    idle(1);
    // R7 U-mode exception delegated; R10 address flagged
    issue("R7_R10 U exception to S", 32'd8, 2'd0, 7'b0000001, 1'b1, 1'b0);
    idle(1);
    // R6 index beyond XLEN falls to machine
    issue("R6 out-of-range index", 32'd40, 2'd0, 7'b0000011, 1'b0, 1'b0);
    idle(1);
    // R5 interrupt uses mideleg
    medeleg = 32'h0000_0000; mideleg = 32'h0000_0020;
    issue("R5_R7 S interrupt via mideleg", 32'h8000_0005, 2'd1, 7'b0000001, 1'b0, 1'b0);
    idle(1);
    medeleg = 32'h0000_0020; mideleg = 32'h0;
    issue("R5_R8_R9 interrupt vectored M", 32'h8000_0005, 2'd1, 7'b0000010, 1'b0, 1'b0);
    idle(1);
    mtvec = 32'h0000_1000;
    issue("R8 interrupt direct M", 32'h8000_0007, 2'd0, 7'b0010010, 1'b1, 1'b0);
    idle(1);
    // R4 breakpoint enters debug from S
    ebk = 3'b010;
    issue("R4 breakpoint enters debug", 32'd3, 2'd1, 7'b1011111, 1'b0, 1'b0);
    idle(1);
    // R4 enable of another privilege has no effect
    issue("R4_R9 breakpoint U not enabled", 32'd3, 2'd0, 7'b0000010, 1'b0, 1'b0);
    idle(1);
    // R3 debug ROM redirects
    issue("R3 breakpoint in debug", 32'd3, 2'd3, 7'b0101010, 1'b1, 1'b1);
    idle(1);
    issue("R3 other trap in debug", 32'd13, 2'd0, 7'b0101010, 1'b1, 1'b1);
    idle(1);
    // R2 back-to-back strobes; R11 reservation on each entry
    medeleg = 32'h0000_2000;
    issue("R2_R11 back-to-back A", 32'd13, 2'd0, 7'b0000001, 1'b1, 1'b0);
    issue("R2_R11 back-to-back B", 32'd13, 2'd3, 7'b0000010, 1'b1, 1'b0);
    issue("R2_R10 back-to-back C", 32'd2, 2'd1, 7'b0000011, 1'b0, 1'b0);
    idle(4);

    checks++;
    if (upd !== 1'b0 || q.size() != 0) begin
      errors++;
      $display("FAIL R2 idle: actual=upd %b pending %0d expected=upd 0 pending 0", upd, q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule